// File: doc/BRIEF.md
# HDLC Frame Transmitter with Message FIFO

This block turns bytes written by a host into a serial HDLC bit stream. The host places each byte in a data staging register. It then writes a control register whose bit 0 marks the last byte of a message. The control write moves the staged byte and that mark together into a 256-entry FIFO as one entry.

On the line side, a serializer moves forward by one bit on every clock cycle in which the bit-enable input is high. While no complete message waits in the FIFO, it sends back-to-back 0x7E flags. Once a complete message is present, it sends the message's bytes with zero-bit stuffing. At the entry carrying the end mark, it appends a frame check sequence and then closing flags.

A message must be at least two bytes long; the host is responsible for this. Full and empty status outputs let the host pace its writes.

Top module: `hdlc_frame_tx`

## Requirements
- R1: A host write with `host_wr` high and `host_addr` = 0 only stages `host_wdata`. A write to `host_addr` = 1 pushes one FIFO entry made of the staged byte plus `host_wdata[0]` as the end-of-message mark. A data write alone leaves `fifo_empty` unchanged.
- R2: `host_rdata` is always zero.
- R3: The FIFO holds 256 entries. A control write while it is full is ignored, so no entry is added and the frame that follows does not contain the rejected byte.
- R4: Each data byte is sent starting with bit 0 and ending with bit 7.
- R5: After the byte marked as end of message, the line carries the FCS and then at least two 0x7E flags before any following frame.
- R6: The FCS is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected (0x8408) over the data bits in line order. It is preset to 0xFFFF, and its ones' complement is sent LSB first.
- R7: Inside data and FCS, a 0 is inserted after every run of five consecutive 1s. Flags are sent unstuffed, so a frame never shows six 1s in a row.
- R8: While the FIFO holds no entry with the end-of-message mark, the line sends only continuous 0x7E flags, even if unfinished message bytes are already queued.
- R9: `fifo_empty` is high exactly when the FIFO holds no entry. `fifo_full` is high exactly when it holds 256 entries. After reset the FIFO is empty.
- R10: `line_bit` changes only on a clock edge where `line_en` was high, and each such edge presents exactly one new line bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Host register select (0 = data stage, 1 = control/commit) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, always zero |
| fifo_full | output | 1 | FIFO holds 256 entries |
| fifo_empty | output | 1 | FIFO holds no entry |
| line_en | input | 1 | Advance the serial line by one bit |
| line_bit | output | 1 | Serial line output |

## Verification
The bench decodes the line with its own flag hunter and de-stuffer, then compares every frame's payload and CRC against the messages it wrote. Bytes full of ones, and bytes that look like flags, are mixed into random messages. A design that skipped a stuff bit, stuffed the flags, or ignored ones carried over from the FCS would either break the flag hunt or show six ones inside a frame. The FIFO is filled to exactly 256 entries with the line stopped, and one extra write is made. If that write were accepted, an extra frame or a wrong byte count would appear. A partial message is left sitting unterminated while the line runs. A design that started frames from any queued byte, instead of only when an end mark is present, would emit a frame early or underrun.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
   typedef enum logic [1:0] {
      TX_FLAG = 2'd0,
      TX_DATA = 2'd1,
      TX_FCS  = 2'd2
   } tx_state_e;

   typedef struct packed {
      logic       last;
      logic [7:0] data;
   } fifo_entry_t;

   localparam logic [7:0] FLAG_OCTET = 8'h7E;
endpackage

// File: rtl/hdlc_tx_host_if.sv
module hdlc_tx_host_if
   import hdlc_tx_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int STAGE_ADR = 0,
   parameter int PUSH_ADR  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [7:0]        wdata,
   output logic              push,
   output fifo_entry_t       push_entry,
   output logic [7:0]        rdata
);
   localparam logic [ADDR_W-1:0] STAGE_A = ADDR_W'(STAGE_ADR);
   localparam logic [ADDR_W-1:0] PUSH_A  = ADDR_W'(PUSH_ADR);

   if (STAGE_ADR == PUSH_ADR) begin : g_bad_map
      $error("stage and push addresses must differ");
   end

   logic [7:0] staged_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q <= 8'h00;
      end else if (wr && addr == STAGE_A) begin
         staged_q <= wdata;
      end
   end

   always_comb begin
      push            = wr && (addr == PUSH_A);
      push_entry.data = staged_q;
      push_entry.last = wdata[0];
   end

   // both host registers are write-only
   assign rdata = 8'h00;
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
   import hdlc_tx_pkg::*;
#(
   parameter int DEPTH = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push,
   input  fifo_entry_t push_entry,
   input  logic        pop,
   output fifo_entry_t head,
   output logic        full,
   output logic        empty,
   output logic        msg_ready
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end

   fifo_entry_t   mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count, msg_count;
   logic          push_ok, pop_ok;

   assign full     = (count == DEPTH_C);
   assign empty    = (count == '0);
   assign push_ok  = push && !full;
   assign pop_ok   = pop && !empty;
   assign head     = mem[rd_ptr];
   assign msg_ready = (msg_count != '0);

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= push_entry;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         count     <= '0;
         msg_count <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         case ({push_ok && push_entry.last, pop_ok && head.last})
            2'b10:   msg_count <= msg_count + 1'b1;
            2'b01:   msg_count <= msg_count - 1'b1;
            default: msg_count <= msg_count;
         endcase
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (full && $stable(wr_ptr)));
   a_r9_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   a_r8_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   a_r8_msgs_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      msg_count <= count);
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs #(
   parameter int FCS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             shift,
   input  logic             din,
   output logic [FCS_W-1:0] fcs_next
);
   logic [FCS_W-1:0] poly;
   logic [FCS_W-1:0] crc_q;
   logic [FCS_W-1:0] crc_d;

   if (FCS_W == 16) begin : g_crc16
      assign poly = 16'h8408;
   end else if (FCS_W == 32) begin : g_crc32
      assign poly = 32'hEDB8_8320;
   end else begin : g_bad_width
      assign poly = '0;
      $error("FCS_W must be 16 or 32");
   end

   always_comb begin
      crc_d = crc_q >> 1;
      if (crc_q[0] ^ din) crc_d = crc_d ^ poly;
   end

   // complemented CRC including the bit being shifted this cycle
   assign fcs_next = ~crc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= '1;
      end else if (init) begin
         crc_q <= '1;
      end else if (shift) begin
         crc_q <= crc_d;
      end
   end
endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
   import hdlc_tx_pkg::*;
#(
   parameter int FCS_W       = 16,
   parameter int CLOSE_FLAGS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             msg_ready,
   input  fifo_entry_t      head,
   output logic             pop,
   output logic             crc_init,
   output logic             crc_shift,
   output logic             crc_din,
   input  logic [FCS_W-1:0] fcs_next,
   output logic             line_bit
);
   localparam int FLW = $clog2(CLOSE_FLAGS + 1);
   localparam int FIW = $clog2(FCS_W);
   localparam logic [FLW-1:0] CLOSE_C = FLW'(CLOSE_FLAGS);
   localparam logic [FIW-1:0] FCS_LAST = FIW'(FCS_W - 1);

   if (CLOSE_FLAGS < 2) begin : g_bad_close
      $error("CLOSE_FLAGS must be at least 2");
   end

   tx_state_e        state;
   logic [2:0]       flag_idx;
   logic [FLW-1:0]   flags_left;
   logic [7:0]       shreg;
   logic             shlast;
   logic [2:0]       bit_idx;
   logic [2:0]       ones;
   logic [FCS_W-1:0] fcs_sh;
   logic [FIW-1:0]   fcs_idx;
   logic             stuff_now;
   logic             data_bit;
   logic             flag_done;

   assign stuff_now = (ones == 3'd5);
   assign data_bit  = shreg[bit_idx];
   assign flag_done = (flag_idx == 3'd7) && (flags_left <= FLW'(1));
   assign crc_din   = data_bit;

   always_comb begin
      pop       = 1'b0;
      crc_init  = 1'b0;
      crc_shift = 1'b0;
      if (bit_en && !stuff_now) begin
         unique case (state)
            TX_FLAG: begin
               if (flag_done && msg_ready) begin
                  pop      = 1'b1;
                  crc_init = 1'b1;
               end
            end
            TX_DATA: begin
               crc_shift = 1'b1;
               if (bit_idx == 3'd7 && !shlast) pop = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TX_FLAG;
         flag_idx   <= 3'd0;
         flags_left <= FLW'(1);
         shreg      <= 8'h00;
         shlast     <= 1'b0;
         bit_idx    <= 3'd0;
         ones       <= 3'd0;
         fcs_sh     <= '0;
         fcs_idx    <= '0;
         line_bit   <= 1'b0;
      end else if (bit_en) begin
         if (stuff_now) begin
            line_bit <= 1'b0;
            ones     <= 3'd0;
         end else begin
            unique case (state)
               TX_FLAG: begin
                  line_bit <= FLAG_OCTET[flag_idx];
                  ones     <= 3'd0;
                  flag_idx <= flag_idx + 3'd1;
                  if (flag_idx == 3'd7) begin
                     if (flags_left > FLW'(1)) begin
                        flags_left <= flags_left - FLW'(1);
                     end else if (msg_ready) begin
                        state   <= TX_DATA;
                        shreg   <= head.data;
                        shlast  <= head.last;
                        bit_idx <= 3'd0;
                     end
                  end
               end
               TX_DATA: begin
                  line_bit <= data_bit;
                  ones     <= data_bit ? ones + 3'd1 : 3'd0;
                  bit_idx  <= bit_idx + 3'd1;
                  if (bit_idx == 3'd7) begin
                     if (shlast) begin
                        state   <= TX_FCS;
                        fcs_sh  <= fcs_next;
                        fcs_idx <= '0;
                     end else begin
                        shreg  <= head.data;
                        shlast <= head.last;
                     end
                  end
               end
               default: begin
                  line_bit <= fcs_sh[0];
                  ones     <= fcs_sh[0] ? ones + 3'd1 : 3'd0;
                  fcs_sh   <= fcs_sh >> 1;
                  fcs_idx  <= fcs_idx + FIW'(1);
                  if (fcs_idx == FCS_LAST) begin
                     state      <= TX_FLAG;
                     flag_idx   <= 3'd0;
                     flags_left <= CLOSE_C;
                  end
               end
            endcase
         end
      end
   end

   a_r7_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= 3'd5);
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(line_bit));
   a_r7_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && stuff_now) |=> !line_bit);
   a_r5_fcs_to_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (state == TX_FCS && bit_en && !stuff_now && fcs_idx == FCS_LAST)
      |=> (state == TX_FLAG && flags_left == CLOSE_C));
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
   import hdlc_tx_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int STAGE_ADR   = 0,
   parameter int PUSH_ADR    = 1,
   parameter int DEPTH       = 256,
   parameter int FCS_W       = 16,
   parameter int CLOSE_FLAGS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   output logic              fifo_full,
   output logic              fifo_empty,
   input  logic              line_en,
   output logic              line_bit
);
   fifo_entry_t      push_entry, head;
   logic             push, pop, msg_ready;
   logic             crc_init, crc_shift, crc_din;
   logic [FCS_W-1:0] fcs_next;

   hdlc_tx_host_if #(
      .ADDR_W(ADDR_W), .STAGE_ADR(STAGE_ADR), .PUSH_ADR(PUSH_ADR)
   ) u_host (
      .clk(clk), .rst_n(rst_n), .addr(host_addr), .wr(host_wr),
      .wdata(host_wdata), .push(push), .push_entry(push_entry),
      .rdata(host_rdata)
   );

   hdlc_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_entry(push_entry),
      .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty),
      .msg_ready(msg_ready)
   );

   hdlc_tx_fcs #(.FCS_W(FCS_W)) u_fcs (
      .clk(clk), .rst_n(rst_n), .init(crc_init), .shift(crc_shift),
      .din(crc_din), .fcs_next(fcs_next)
   );

   hdlc_tx_serializer #(.FCS_W(FCS_W), .CLOSE_FLAGS(CLOSE_FLAGS)) u_ser (
      .clk(clk), .rst_n(rst_n), .bit_en(line_en), .msg_ready(msg_ready),
      .head(head), .pop(pop), .crc_init(crc_init), .crc_shift(crc_shift),
      .crc_din(crc_din), .fcs_next(fcs_next), .line_bit(line_bit)
   );
endmodule

// File: tb/hdlc_frame_tx_test.sv
`timescale 1ns/1ps
module hdlc_frame_tx_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] host_addr = 4'd0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic       fifo_full, fifo_empty;
   logic       line_en = 1'b0;
   logic       line_bit;

   int  n_checks = 0, n_fail = 0;
   bit  line_on = 1'b0;
   bit  finished = 1'b0;
   int  frames_done = 0, msgs_sent = 0;
   byte unsigned exp_bytes[$];
   int  exp_len[$];
   int  ones = 0, flags_gap = 0;
   bit  seen_frame = 1'b0;
   bit  rbuf[$];
   logic last_bit = 1'b0;

   always #10 clk = ~clk;

   hdlc_frame_tx uut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .line_en(line_en), .line_bit(line_bit)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_fcs(input byte unsigned b[$]);
      logic [15:0] c = 16'hFFFF;
      foreach (b[i]) begin
         for (int k = 0; k < 8; k++) begin
            if (c[0] ^ b[i][k]) c = (c >> 1) ^ 16'h8408;
            else c = c >> 1;
         end
      end
      return ~c;
   endfunction

   task automatic frame_end();
      int nb = rbuf.size() / 8;
      byte unsigned got[$];
      int n;
      logic [15:0] fcs_got;
      check(rbuf.size() % 8 == 0 && nb >= 4, "R5 frame bit count", rbuf.size(), 32);
      for (int i = 0; i < nb; i++) begin
         byte unsigned v = 0;
         for (int k = 0; k < 8; k++) v[k] = rbuf[i*8 + k];   // R4 bit 0 first
         got.push_back(v);
      end
      if (seen_frame) check(flags_gap >= 1, "R5 two closing flags", flags_gap + 1, 2);
      frames_done++;
      if (exp_len.size() == 0) begin
         check(1'b0, "R3 unexpected frame", nb, 0);
      end else begin
         byte unsigned pay[$];
         n = exp_len.pop_front();
         check(nb - 2 == n, "R3 payload length", nb - 2, n);
         for (int i = 0; i < n; i++) begin
            byte unsigned e = exp_bytes.pop_front();
            pay.push_back(e);
            if (i < nb - 2) check(got[i] == e, "R4 payload byte", got[i], e);
         end
         if (nb >= 2) begin
            fcs_got = {got[nb-1], got[nb-2]};
            check(fcs_got == ref_fcs(pay), "R6 fcs", fcs_got, ref_fcs(pay));
         end
      end
      seen_frame = 1'b1;
      flags_gap = 0;
      rbuf.delete();
   endtask

   task automatic rx_bit(input bit b);
      if (b) begin
         ones++;
         rbuf.push_back(1'b1);
         if (ones == 7) check(1'b0, "R7 run of ones", ones, 6);
      end else begin
         if (ones == 5) begin
            // stuffed zero dropped
         end else if (ones == 6) begin
            for (int i = 0; i < 7; i++) if (rbuf.size() > 0) void'(rbuf.pop_back());
            if (rbuf.size() > 0) frame_end();
            else flags_gap++;
         end else begin
            rbuf.push_back(1'b0);
         end
         ones = 0;
      end
   endtask

   initial begin : line_side
      forever begin
         @(negedge clk);
         if (line_en) begin
            rx_bit(line_bit);
            last_bit = line_bit;
         end else if (rst_n) begin
            if (line_bit !== last_bit) check(1'b0, "R10 hold when disabled", line_bit, last_bit);
         end
         line_en = line_on && ($urandom_range(3) != 0);
      end
   end

   task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic send_msg(input byte unsigned m[$]);
      foreach (m[i]) begin
         hwrite(4'd0, m[i]);
         hwrite(4'd1, (i == m.size() - 1) ? 8'h01 : 8'h00);
         exp_bytes.push_back(m[i]);
      end
      exp_len.push_back(m.size());
      msgs_sent++;
   endtask

   task automatic drain();
      for (int i = 0; i < 60000 && exp_len.size() != 0; i++) @(negedge clk);
      check(exp_len.size() == 0, "R5 all frames drained", exp_len.size(), 0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      byte unsigned m[$];
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fifo_empty == 1'b1, "R9 empty after reset", fifo_empty, 1);
      check(fifo_full == 1'b0, "R9 not full after reset", fifo_full, 0);
      check(host_rdata == 8'h00, "R2 read zero", host_rdata, 0);
      line_on = 1'b1;
      repeat (150) @(negedge clk);
      check(frames_done == 0 && flags_gap >= 5, "R8 idle flags", flags_gap, 5);

      // R1 staging alone does not commit
      hwrite(4'd0, 8'hA5);
      check(fifo_empty == 1'b1, "R1 stage only", fifo_empty, 1);
      hwrite(4'd1, 8'h00);
      check(fifo_empty == 1'b0, "R1 commit", fifo_empty, 0);
      repeat (300) @(negedge clk);
      check(frames_done == 0, "R8 partial message held", frames_done, 0);
      check(fifo_empty == 1'b0, "R8 partial stays queued", fifo_empty, 0);
      exp_bytes.push_back(8'hA5);
      hwrite(4'd0, 8'h3C);
      hwrite(4'd1, 8'h01);
      exp_bytes.push_back(8'h3C);
      exp_len.push_back(2);
      msgs_sent++;

      m = '{8'hFF, 8'hFF, 8'hFF, 8'hFF};          // R7 long runs of ones
      send_msg(m);
      m = '{8'h7E, 8'h3F, 8'hFC, 8'h7E, 8'h1F};   // R7 flag look-alikes
      send_msg(m);
      m = '{8'h00, 8'h00};
      send_msg(m);

      for (int t = 0; t < 25; t++) begin
         int len = $urandom_range(16, 2);
         m.delete();
         for (int i = 0; i < len; i++)
            m.push_back(($urandom_range(3) == 0) ? 8'hFF : 8'($urandom));
         send_msg(m);
      end
      drain();

      // R3 fill to capacity with the line stopped
      line_on = 1'b0;
      repeat (8) @(negedge clk);
      m.delete();
      for (int i = 0; i < 256; i++) m.push_back(8'($urandom));
      send_msg(m);
      check(fifo_full == 1'b1, "R3 full at 256", fifo_full, 1);
      check(fifo_empty == 1'b0, "R9 not empty when full", fifo_empty, 0);
      hwrite(4'd0, 8'h99);
      hwrite(4'd1, 8'h01);
      check(fifo_full == 1'b1, "R3 write while full ignored", fifo_full, 1);
      check(host_rdata == 8'h00, "R2 read zero when full", host_rdata, 0);
      line_on = 1'b1;
      drain();
      repeat (200) @(negedge clk);
      check(frames_done == msgs_sent, "R3 frame count", frames_done, msgs_sent);
      check(fifo_empty == 1'b1, "R9 empty after drain", fifo_empty, 1);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule